// File: doc/BRIEF.md
# Staggered Sixteen-Lane SAD Block Matcher

This block runs a full-search block match for one 16x16 luminance block over a displacement range of -8 to +7 pixels in both directions. Software loads two things through a simple write port: the current block, and a 31x31 reference window whose pixel (8,8) lies under the block's top-left corner. After a start pulse, the block scores all 256 candidate displacements by sum of absolute differences (SAD). It then reports the smallest score together with its displacement as a signed motion vector.

Sixteen processing lanes work side by side. Lane k handles horizontal displacement k-8. The search runs as sixteen groups, one for each vertical displacement. The current-block pixel enters lane 0 and moves one lane further each cycle, so lane k begins its 256-pixel accumulation one cycle after lane k-1 and reuses the pixel that its neighbour has just used. Because of this skew, at any cycle the lanes need at most two distinct reference pixels. One comes from the left half of the window and one from the right half. Each lane picks between these two read ports through its own multiplexer. As each lane finishes, a single comparator scans the sixteen results in lane order.

Top module: `sad_linear_array`

## Requirements
- R1: While reset is held and directly after it, busy, done, best_sad, best_dx and best_dy are all zero.
- R2: A high start sampled at a rising edge while busy is low begins a search. busy is high from that edge up to and including the 4352nd rising edge after it (16 groups of 272 cycles). done is high for exactly one cycle, following the 4353rd rising edge after the start edge, and busy is low while done is high.
- R3: A write with wr_win=0 stores wr_data as current pixel (row r, column c) at wr_addr = r*16+c. A write with wr_win=1 stores window pixel (row y, column x) at wr_addr = y*31+x. Candidate (dx,dy) pairs current pixel (r,c) with window pixel (8+dy+r, 8+dx+c). At done, best_sad equals the smallest SAD over all 256 candidates.
- R4: At done, best_dx and best_dy give the displacement of the reported candidate as 4-bit two's complement values in the range -8..7.
- R5: When several candidates share the minimum SAD, the one reported is the first in scan order. Scan order runs by dy ascending, then by dx ascending within each dy.
- R6: A start pulse while busy is high is ignored. The running search keeps its timing and its result.
- R7: best_sad, best_dx and best_dy keep their values from one done pulse to the next, including throughout the following search.
- R8: The largest possible SAD, 65280 (all 256 pairs differing by 255), is reported exactly, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Pixel write strobe |
| wr_win | input | 1 | Write target: 0 current block, 1 reference window |
| wr_addr | input | 10 | Flat pixel index, row-major |
| wr_data | input | 8 | Pixel value |
| start | input | 1 | Begin a search when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| best_sad | output | 16 | Minimum SAD of the last search |
| best_dx | output | 4 | Horizontal displacement of the best match, signed |
| best_dy | output | 4 | Vertical displacement of the best match, signed |

## Verification
The bench places exact matches at the corners of the range, (-8,+7) and (+7,-8). A lane multiplexer that switches ports at the wrong column, or an address clamp that is off by one, would then report a non-zero score or the wrong vector. A horizontally periodic window produces four equal minima in one row, and a flat window makes all 256 scores equal. A comparator using less-or-equal, or one that resets between groups, would then report a later candidate. An all-255 window against an all-zero block drives every accumulator to its ceiling, so an accumulator that is too narrow would wrap. A start pulse injected mid-search must not move the done pulse by a single cycle.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int PIX_W = 8;

  // Absolute difference of two unsigned pixels.
  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // Flat row-major index inside a square window, with each coordinate clamped to the edge.
  function automatic int win_index(input int row, input int col, input int side);
    int r;
    int c;
    r = (row > side - 1) ? side - 1 : row;
    c = (col > side - 1) ? side - 1 : col;
    return r * side + c;
  endfunction

endpackage

// File: rtl/sad_scan_ctrl.sv
module sad_scan_ctrl
  import sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  localparam int NPE    = 2 * RANGE,
  localparam int WIN    = BLK + NPE - 1,
  localparam int PIX    = BLK * BLK,
  localparam int PERIOD = PIX + NPE,
  localparam int T_W    = $clog2(PERIOD),
  localparam int G_W    = $clog2(NPE),
  localparam int L_W    = $clog2(BLK),
  localparam int PIX_AW = $clog2(PIX),
  localparam int WIN_AW = $clog2(WIN * WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [PIX_AW-1:0] cur_addr,
  output logic [WIN_AW-1:0] s1_addr,
  output logic [WIN_AW-1:0] s2_addr,
  output logic [L_W-1:0]    lane,
  output logic [T_W-1:0]    t1,
  output logic [G_W-1:0]    g1,
  output logic              v1,
  output logic              cmp_en,
  output logic [G_W-1:0]    cmp_idx,
  output logic              fresh,
  output logic              done_evt
);

  logic           run;
  logic [T_W-1:0] t;
  logic [G_W-1:0] g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      t   <= '0;
      g   <= '0;
      t1  <= '0;
      g1  <= '0;
      v1  <= 1'b0;
    end else begin
      v1 <= run;
      t1 <= t;
      g1 <= g;
      if (!run) begin
        if (start && !v1) begin
          run <= 1'b1;
          t   <= '0;
          g   <= '0;
        end
      end else if (t == T_W'(PERIOD - 1)) begin
        t <= '0;
        if (g == G_W'(NPE - 1)) run <= 1'b0;
        else                    g   <= g + 1'b1;
      end else begin
        t <= t + 1'b1;
      end
    end
  end

  assign busy = run | v1;

  // Lanes at or left of column m work on block row q (left port).
  // Lanes to its right still work on row q-1 (right port).
  always_comb begin
    int q;
    int m;
    q = int'(t) / BLK;
    m = int'(t) % BLK;
    lane     = L_W'(m);
    cur_addr = PIX_AW'(t);
    s1_addr  = WIN_AW'(win_index(int'(g) + q, m, WIN));
    s2_addr  = WIN_AW'(win_index((q == 0) ? 0 : int'(g) + q - 1, m + BLK, WIN));
  end

  assign cmp_en   = v1 && (int'(t1) >= PIX) && (int'(t1) < PERIOD);
  assign cmp_idx  = G_W'(int'(t1) - PIX);
  assign fresh    = cmp_en && (g1 == '0) && (int'(t1) == PIX);
  assign done_evt = v1 && (g1 == G_W'(NPE - 1)) && (t1 == T_W'(PERIOD - 1));

  assert_restart_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !$past(busy));

  assert_single_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);

endmodule

// File: rtl/sad_pe.sv
module sad_pe
  import sad_pkg::*;
#(
  parameter int K     = 0,
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  localparam int NPE    = 2 * RANGE,
  localparam int PIX    = BLK * BLK,
  localparam int PERIOD = PIX + NPE,
  localparam int T_W    = $clog2(PERIOD),
  localparam int L_W    = $clog2(BLK),
  localparam int SAD_W  = $clog2(PIX * 255 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] cur_in,
  input  logic [PIX_W-1:0] s1_pix,
  input  logic [PIX_W-1:0] s2_pix,
  input  logic [L_W-1:0]   lane,
  input  logic [T_W-1:0]   t1,
  input  logic             v1,
  output logic [PIX_W-1:0] cur_q,
  output logic [SAD_W-1:0] acc,
  output logic             pe_first
);

  logic [PIX_W-1:0] srch_q;
  logic [PIX_W-1:0] diff;
  logic             active;

  assign active   = v1 && (int'(t1) >= K) && (int'(t1) < K + PIX);
  assign pe_first = v1 && (int'(t1) == K);
  assign diff     = abs_diff(cur_q, srch_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      srch_q <= '0;
      acc    <= '0;
    end else begin
      cur_q  <= cur_in;
      srch_q <= (K <= int'(lane)) ? s1_pix : s2_pix;
      if (active) acc <= pe_first ? SAD_W'(diff) : acc + SAD_W'(diff);
    end
  end

  assert_acc_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pe_first) |=> (acc >= $past(acc)));

endmodule

// File: rtl/sad_best_pick.sv
module sad_best_pick #(
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  localparam int NPE   = 2 * RANGE,
  localparam int PIX   = BLK * BLK,
  localparam int G_W   = $clog2(NPE),
  localparam int SAD_W = $clog2(PIX * 255 + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SAD_W-1:0]      acc [NPE],
  input  logic                  cmp_en,
  input  logic [G_W-1:0]        cmp_idx,
  input  logic [G_W-1:0]        g1,
  input  logic                  fresh,
  input  logic                  done_evt,
  output logic [SAD_W-1:0]      best_sad,
  output logic signed [G_W-1:0] best_dx,
  output logic signed [G_W-1:0] best_dy,
  output logic                  done
);

  logic [SAD_W-1:0] run_sad, cand, nxt_sad;
  logic [G_W-1:0]   run_x, run_y, nxt_x, nxt_y;
  logic             take;

  assign cand    = acc[cmp_idx];
  assign take    = fresh || (cand < run_sad);   // strict: earlier candidate wins ties
  assign nxt_sad = take ? cand    : run_sad;
  assign nxt_x   = take ? cmp_idx : run_x;
  assign nxt_y   = take ? g1      : run_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sad  <= '0;
      run_x    <= '0;
      run_y    <= '0;
      best_sad <= '0;
      best_dx  <= '0;
      best_dy  <= '0;
      done     <= 1'b0;
    end else begin
      done <= done_evt;
      if (cmp_en) begin
        run_sad <= nxt_sad;
        run_x   <= nxt_x;
        run_y   <= nxt_y;
      end
      if (done_evt) begin
        best_sad <= nxt_sad;
        best_dx  <= nxt_x - G_W'(RANGE);
        best_dy  <= nxt_y - G_W'(RANGE);
      end
    end
  end

  assert_best_never_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !fresh) |=> (run_sad <= $past(run_sad)));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(best_sad) && $stable(best_dx) && $stable(best_dy)));

endmodule

// File: rtl/sad_linear_array.sv
module sad_linear_array #(
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  localparam int NPE    = 2 * RANGE,
  localparam int WIN    = BLK + NPE - 1,
  localparam int PIX    = BLK * BLK,
  localparam int PERIOD = PIX + NPE,
  localparam int T_W    = $clog2(PERIOD),
  localparam int G_W    = $clog2(NPE),
  localparam int L_W    = $clog2(BLK),
  localparam int PIX_AW = $clog2(PIX),
  localparam int WIN_AW = $clog2(WIN * WIN),
  localparam int SAD_W  = $clog2(PIX * 255 + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_win,
  input  logic [WIN_AW-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [SAD_W-1:0]      best_sad,
  output logic signed [G_W-1:0] best_dx,
  output logic signed [G_W-1:0] best_dy
);

  logic [7:0] cur_mem [PIX];
  logic [7:0] win_mem [WIN * WIN];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_win && (int'(wr_addr) < PIX)) cur_mem[wr_addr[PIX_AW-1:0]] <= wr_data;
    if (wr_en &&  wr_win && (int'(wr_addr) < WIN * WIN)) win_mem[wr_addr] <= wr_data;
  end

  logic [PIX_AW-1:0] cur_addr;
  logic [WIN_AW-1:0] s1_addr, s2_addr;
  logic [L_W-1:0]    lane;
  logic [T_W-1:0]    t1;
  logic [G_W-1:0]    g1, cmp_idx;
  logic              v1, cmp_en, fresh, done_evt;

  sad_scan_ctrl #(.BLK(BLK), .RANGE(RANGE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cur_addr(cur_addr), .s1_addr(s1_addr), .s2_addr(s2_addr), .lane(lane),
    .t1(t1), .g1(g1), .v1(v1), .cmp_en(cmp_en), .cmp_idx(cmp_idx),
    .fresh(fresh), .done_evt(done_evt)
  );

  logic [7:0]       s1_pix, s2_pix;
  logic [7:0]       cur_chain [NPE + 1];
  logic [SAD_W-1:0] acc       [NPE];
  logic [NPE-1:0]   pe_first;

  assign s1_pix       = win_mem[s1_addr];
  assign s2_pix       = win_mem[s2_addr];
  assign cur_chain[0] = cur_mem[cur_addr];

  for (genvar k = 0; k < NPE; k++) begin : g_lane
    sad_pe #(.K(k), .BLK(BLK), .RANGE(RANGE)) u_pe (
      .clk(clk), .rst_n(rst_n), .cur_in(cur_chain[k]),
      .s1_pix(s1_pix), .s2_pix(s2_pix), .lane(lane), .t1(t1), .v1(v1),
      .cur_q(cur_chain[k+1]), .acc(acc[k]), .pe_first(pe_first[k])
    );
    if (k > 0) begin : g_skew
      assert_lane_skew_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pe_first[k] |-> $past(pe_first[k-1]));
    end
  end

  sad_best_pick #(.BLK(BLK), .RANGE(RANGE)) u_pick (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cmp_en(cmp_en), .cmp_idx(cmp_idx),
    .g1(g1), .fresh(fresh), .done_evt(done_evt),
    .best_sad(best_sad), .best_dx(best_dx), .best_dy(best_dy), .done(done)
  );

  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_one_start_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pe_first));

endmodule

// File: tb/sad_linear_array_bench.sv
module sad_linear_array_bench;

  localparam int NPE       = 16;
  localparam int BLK       = 16;
  localparam int WIN       = 31;
  localparam int PIX       = 256;
  localparam int DONE_EDGE = NPE * (PIX + NPE) + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_win = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [15:0] best_sad;
  logic signed [3:0] best_dx, best_dy;

  always #4 clk = ~clk;

  sad_linear_array u_sad_linear_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done),
    .best_sad(best_sad), .best_dx(best_dx), .best_dy(best_dy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int seed = 7;
  int wmem [WIN * WIN];
  int cmem [PIX];
  int per  [WIN][4];
  int exp_sad, exp_dx, exp_dy;
  int prev_sad = 0, prev_dx = 0, prev_dy = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  task automatic load_mems();
    for (int i = 0; i < PIX; i++) begin
      @(negedge clk); wr_en = 1; wr_win = 0; wr_addr = 10'(i); wr_data = 8'(cmem[i]);
    end
    for (int i = 0; i < WIN * WIN; i++) begin
      @(negedge clk); wr_en = 1; wr_win = 1; wr_addr = 10'(i); wr_data = 8'(wmem[i]);
    end
    @(negedge clk); wr_en = 0;
  endtask

  // Reference: exhaustive scan in dy-major, dx-minor order, strict minimum.
  task automatic model();
    exp_sad = 1 << 30;
    for (int dy = -8; dy <= 7; dy++)
      for (int dx = -8; dx <= 7; dx++) begin
        int s = 0;
        for (int r = 0; r < BLK; r++)
          for (int c = 0; c < BLK; c++) begin
            int d = cmem[r*BLK+c] - wmem[(8+dy+r)*WIN + 8+dx+c];
            s += (d < 0) ? -d : d;
          end
        if (s < exp_sad) begin exp_sad = s; exp_dx = dx; exp_dy = dy; end
      end
  endtask

  task automatic copy_block(input int dx, input int dy);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        cmem[r*BLK+c] = wmem[(8+dy+r)*WIN + 8+dx+c];
  endtask

  // Cycle-by-cycle comparison of busy/done against the expected schedule.
  task automatic run(input bit poke);
    int done_at = -1;
    int done_cnt = 0;
    model();
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    for (int j = 1; j <= DONE_EDGE + 3; j++) begin
      @(posedge clk);
      @(negedge clk);
      start = (poke && (j == 100)) ? 1'b1 : 1'b0;
      chk(busy == (j < DONE_EDGE), "R2 busy", int'(busy), int'(j < DONE_EDGE));
      chk(done == (j == DONE_EDGE), "R2 done", int'(done), int'(j == DONE_EDGE));
      if (done) begin done_at = j; done_cnt++; end
      if (j < DONE_EDGE) begin
        chk(int'(best_sad) == prev_sad && int'(best_dx) == prev_dx && int'(best_dy) == prev_dy,
            "R7 hold", int'(best_sad), prev_sad);
      end
      if (j == DONE_EDGE) begin
        chk(int'(best_sad) == exp_sad, "R3 sad", int'(best_sad), exp_sad);
        chk(int'(best_dx) == exp_dx, "R4 dx", int'(best_dx), exp_dx);
        chk(int'(best_dy) == exp_dy, "R4 dy", int'(best_dy), exp_dy);
      end
    end
    if (poke) chk(done_cnt == 1 && done_at == DONE_EDGE, "R6 start ignored", done_at, DONE_EDGE);
    prev_sad = int'(best_sad);
    prev_dx  = int'(best_dx);
    prev_dy  = int'(best_dy);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !done, "R1 flags", int'({busy, done}), 0);
    chk(best_sad == 0 && best_dx == 0 && best_dy == 0, "R1 result", int'(best_sad), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && best_sad == 0, "R1 after release", int'(best_sad), 0);

    // R3/R4: exact match at (+3,-5) in random data
    for (int i = 0; i < WIN * WIN; i++) wmem[i] = rnd();
    copy_block(3, -5);
    load_mems();
    run(0);
    chk(int'(best_dx) == 3 && int'(best_dy) == -5, "R4 planted vector", int'(best_dx), 3);

    // R5: horizontally periodic window, four equal minima in row dy=2
    for (int y = 0; y < WIN; y++) for (int p = 0; p < 4; p++) per[y][p] = rnd();
    for (int y = 0; y < WIN; y++) for (int x = 0; x < WIN; x++) wmem[y*WIN+x] = per[y][x % 4];
    copy_block(1, 2);
    load_mems();
    run(0);
    chk(int'(best_dx) == -7 && int'(best_dy) == 2, "R5 earliest tie", int'(best_dx), -7);

    // R8 and R5: all 255 against all 0, every score is 65280
    for (int i = 0; i < WIN * WIN; i++) wmem[i] = 255;
    for (int i = 0; i < PIX; i++) cmem[i] = 0;
    load_mems();
    run(0);
    chk(int'(best_sad) == 65280, "R8 full scale", int'(best_sad), 65280);
    chk(int'(best_dx) == -8 && int'(best_dy) == -8, "R5 all equal", int'(best_dx), -8);

    // R6 and corner: match at (-8,+7), start pulsed mid-search
    for (int i = 0; i < WIN * WIN; i++) wmem[i] = rnd();
    copy_block(-8, 7);
    load_mems();
    run(1);
    chk(int'(best_sad) == 0 && int'(best_dx) == -8 && int'(best_dy) == 7, "R3 corner low-left",
        int'(best_sad), 0);

    // Opposite corner (+7,-8) with noise added to the block
    for (int i = 0; i < WIN * WIN; i++) wmem[i] = rnd();
    copy_block(7, -8);
    for (int i = 0; i < PIX; i += 5) cmem[i] = (cmem[i] + 3) & 255;
    load_mems();
    run(0);
    chk(int'(best_dx) == 7 && int'(best_dy) == -8, "R4 corner high-right", int'(best_dx), 7);

    repeat (20) @(negedge clk);
    chk(int'(best_sad) == prev_sad && !done, "R7 idle hold", int'(best_sad), prev_sad);
    summary();
  end

endmodule